// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel with Error-Tagged FIFO

The block is the receive half of one channel of a dual asynchronous serial controller. It watches a serial input line, waits for a start bit while reception is enabled, and then samples the line once per bit period. The bit period is the system clock divided by a factor of 1, 16, 32 or 64. A character carries 5 to 8 data bits, sent least significant bit first, an optional parity bit and one or two stop bits. The block checks each character for parity and framing errors and stores it, with its error tags, in a three-entry FIFO.

Software or a host state machine takes characters from the data-read port. Each read copies the popped entry's error tags into a status view. The parity and overrun flags stay set until an error-reset command clears them, while the framing flag reflects the most recent read. For every stored character an interrupt-request pulse may be sent, with a type code that tells an ordinary receive event from a special condition. Which characters raise a request depends on one of four receive-interrupt modes. One of these modes raises a request only for the next character after an explicit arm command.

Top module: `serial_rx_channel`

## Requirements
- R1: `cfg_clk_mode` selects the sampling divisor D: 00 gives 1, 01 gives 16, 10 gives 32 and 11 gives 64. The first data bit is sampled D + floor(D/2) clocks after the clock edge that detects the start bit. Every later bit is sampled D clocks after the previous one.
- R2: `cfg_word_len` selects the number of data bits: 00 gives 5, 10 gives 6, 01 gives 7 and 11 gives 8. The first bit received lands in `rd_data[0]`, and the bits above the word length read as zero.
- R3: A low level on `rx_serial` starts a character only while `cfg_rx_en` is 1. With the enable at 0 a complete frame leaves the FIFO empty and raises no interrupt.
- R4: When `cfg_par_en` is 1, a parity bit follows the data bits. With `cfg_par_even` = 1 it must equal the XOR of the data bits, and with 0 its inverse. A mismatch tags that character with a parity error.
- R5: `cfg_stop` = 11 selects two stop bits, and any other value selects one. A stop bit sampled low tags the character with a framing error. This applies to the first stop bit as well as the last.
- R6: The FIFO holds up to three characters and returns them oldest first. `st_char_avail` is 1 exactly while the FIFO is not empty.
- R7: A character that arrives while the FIFO is full and no read occurs in the same cycle replaces the newest entry and tags it with an overrun. The two older entries are kept.
- R8: A read (`rd_en` while a character is available) updates `rd_data` on the next clock edge and copies the entry's tags into the status view. `st_framing_err` takes the popped entry's value, while `st_parity_err` and `st_overrun_err` are only ever set by a read. A read of an empty FIFO changes nothing.
- R9: A `cmd_err_reset` pulse clears all three error flags at the next clock edge.
- R10: One clock after a character is stored, the block may drive a one-cycle `irq_req` pulse with `irq_type` 10 (receive) or 11 (special). Mode 00 raises none. Mode 10 raises special on any parity, framing or overrun error and receive otherwise. Mode 11 raises special on a framing error or overrun and receive otherwise, including on parity errors.
- R11: In mode 01 a `cmd_arm_first` pulse arms the channel. The next stored character raises a receive request and disarms it. A stored character with an error while disarmed raises a special request, and a clean one raises nothing.
- R12: A synchronous active-high `rst` empties the FIFO, clears all flags, the output data and the armed state, and returns the receiver to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_serial | input | 1 | Serial receive line, idle high |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_clk_mode | input | 2 | Sampling divisor select |
| cfg_word_len | input | 2 | Data bits per character |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_stop | input | 2 | Stop-bit count select |
| cfg_irq_mode | input | 2 | Receive interrupt mode |
| cmd_arm_first | input | 1 | Arm first-character interrupt (pulse) |
| cmd_err_reset | input | 1 | Clear error flags (pulse) |
| rd_en | input | 1 | Pop one character (pulse) |
| rd_data | output | 8 | Last character read, right-justified |
| st_char_avail | output | 1 | FIFO not empty |
| st_parity_err | output | 1 | Sticky parity error flag |
| st_overrun_err | output | 1 | Sticky overrun flag |
| st_framing_err | output | 1 | Framing tag of last character read |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_type | output | 2 | 10 receive, 11 special condition |

## Verification
The assertions assume that the configuration inputs stay constant while a character is in flight. For example, the check that bits above the word length are zero compares the stored data against the word-length setting applied at that moment. The error-flag check assumes that `cmd_err_reset` and a read do not occur in the same cycle. The stimulus meets both assumptions: it changes the configuration only while the line is idle and the previous character has been stored, and it issues commands and reads on separate clock cycles. Serial bits change only on bit-period boundaries set by the bench's own divisor, so each sample falls in the middle of a bit.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_DATA  = 3'd1,
    S_PAR   = 3'd2,
    S_STOP1 = 3'd3,
    S_STOP2 = 3'd4
  } rx_state_e;

  localparam logic [1:0] IRQ_RX      = 2'b10;
  localparam logic [1:0] IRQ_SPECIAL = 2'b11;

  localparam logic [1:0] IM_OFF     = 2'b00;
  localparam logic [1:0] IM_FIRST   = 2'b01;
  localparam logic [1:0] IM_ALL_ERR = 2'b10;
  localparam logic [1:0] IM_ALL     = 2'b11;

  typedef struct packed {
    logic              ovr;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  function automatic logic [3:0] word_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd5;
      2'b01:   return 4'd7;
      2'b10:   return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
  parameter int DIV_LO = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       restart,
  input  logic       active,
  output logic       tick
);
  localparam int MAX_LOAD = 6 * DIV_LO;
  localparam int CNT_W    = $clog2(MAX_LOAD + 1);

  logic [CNT_W-1:0] div_w;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    case (mode)
      2'b00:   div_w = CNT_W'(1);
      2'b01:   div_w = CNT_W'(DIV_LO);
      2'b10:   div_w = CNT_W'(2 * DIV_LO);
      default: div_w = CNT_W'(4 * DIV_LO);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= div_w + (div_w >> 1) - CNT_W'(1);
    end else if (active) begin
      if (cnt == '0) cnt <= div_w - CNT_W'(1);
      else           cnt <= cnt - CNT_W'(1);
    end
  end

  assign tick = active && !restart && (cnt == '0);

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt < CNT_W'(MAX_LOAD)));

endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              serial_in,
  input  logic              rx_en,
  input  logic [1:0]        word_code,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              two_stop,
  input  logic              tick,
  output logic              restart,
  output logic              active,
  output logic              push_q,
  output rx_entry_t         entry_q
);
  rx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [2:0]        bitcnt;
  logic              par_acc;
  logic              perr;
  logic              ferr;
  logic [3:0]        nbits;

  assign nbits   = word_bits(word_code);
  assign restart = (state == S_IDLE) && rx_en && !serial_in;
  assign active  = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      shreg   <= '0;
      bitcnt  <= '0;
      par_acc <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      push_q  <= 1'b0;
      entry_q <= '0;
    end else begin
      push_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (restart) begin
            state   <= S_DATA;
            shreg   <= '0;
            bitcnt  <= '0;
            par_acc <= 1'b0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
          end
        end
        S_DATA: begin
          if (tick) begin
            shreg[bitcnt] <= serial_in;
            par_acc       <= par_acc ^ serial_in;
            bitcnt        <= bitcnt + 3'd1;
            if ({1'b0, bitcnt} == nbits - 4'd1) begin
              if (par_en)        state <= S_PAR;
              else if (two_stop) state <= S_STOP1;
              else               state <= S_STOP2;
            end
          end
        end
        S_PAR: begin
          if (tick) begin
            perr  <= (serial_in != (par_even ? par_acc : !par_acc));
            state <= two_stop ? S_STOP1 : S_STOP2;
          end
        end
        S_STOP1: begin
          if (tick) begin
            if (!serial_in) ferr <= 1'b1;
            state <= S_STOP2;
          end
        end
        S_STOP2: begin
          if (tick) begin
            push_q       <= 1'b1;
            entry_q.data <= shreg;
            entry_q.par  <= perr;
            entry_q.frm  <= ferr | !serial_in;
            entry_q.ovr  <= 1'b0;
            state        <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_idle_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !rx_en) |=> (state == S_IDLE));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    push_q |-> ((entry_q.data >> nbits) == '0));

  p_push_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    push_q |=> !push_q);

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  rx_entry_t                  push_entry,
  input  logic                       pop,
  output rx_entry_t                  head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       ovr_event
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, prev_ptr, wr_addr;
  logic             full, empty, do_pop, do_write;
  rx_entry_t        wr_data;

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign do_pop    = pop && !empty;
  assign ovr_event = push && full && !do_pop;
  assign do_write  = push && !ovr_event;
  assign prev_ptr  = (wr_ptr == '0) ? LAST : wr_ptr - PTR_W'(1);

  always_comb begin
    wr_addr = ovr_event ? prev_ptr : wr_ptr;
    wr_data = push_entry;
    if (ovr_event) wr_data.ovr = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_addr] <= wr_data;
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_write) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (do_pop)   rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      case ({do_write, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  p_overwrite_keeps_full_r7: assert property (@(posedge clk) disable iff (rst)
    ovr_event |=> (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/srx_irq.sv
module srx_irq
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic       par_err,
  input  logic       frm_err,
  input  logic       overrun,
  input  logic [1:0] mode,
  input  logic       arm,
  output logic       irq_q,
  output logic [1:0] type_q
);
  logic armed;
  logic any_err;

  assign any_err = par_err | frm_err | overrun;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      irq_q  <= 1'b0;
      type_q <= 2'b00;
    end else begin
      irq_q <= 1'b0;
      if (push) begin
        case (mode)
          IM_FIRST: begin
            if (armed) begin
              irq_q  <= 1'b1;
              type_q <= IRQ_RX;
              armed  <= 1'b0;
            end else if (any_err) begin
              irq_q  <= 1'b1;
              type_q <= IRQ_SPECIAL;
            end
          end
          IM_ALL_ERR: begin
            irq_q  <= 1'b1;
            type_q <= any_err ? IRQ_SPECIAL : IRQ_RX;
          end
          IM_ALL: begin
            irq_q  <= 1'b1;
            type_q <= (frm_err | overrun) ? IRQ_SPECIAL : IRQ_RX;
          end
          default: ;
        endcase
      end
      if (arm) armed <= 1'b1;
    end
  end

  p_irq_after_push_r10: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(push));

  p_first_disarm_r11: assert property (@(posedge clk) disable iff (rst)
    (mode == IM_FIRST && armed && push && !arm) |=> !armed);

  p_off_silent_r10: assert property (@(posedge clk) disable iff (rst)
    (push && mode == IM_OFF) |=> !irq_q);

endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
  import srx_pkg::*;
#(
  parameter int DIV_LO     = 16,
  parameter int FIFO_DEPTH = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_serial,
  input  logic        cfg_rx_en,
  input  logic [1:0]  cfg_clk_mode,
  input  logic [1:0]  cfg_word_len,
  input  logic        cfg_par_en,
  input  logic        cfg_par_even,
  input  logic [1:0]  cfg_stop,
  input  logic [1:0]  cfg_irq_mode,
  input  logic        cmd_arm_first,
  input  logic        cmd_err_reset,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  output logic        st_char_avail,
  output logic        st_parity_err,
  output logic        st_overrun_err,
  output logic        st_framing_err,
  output logic        irq_req,
  output logic [1:0]  irq_type
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             tick, restart, active, push;
  rx_entry_t        new_entry, head;
  logic [CNT_W-1:0] count;
  logic             ovr_event, pop_ok;

  srx_baud #(.DIV_LO(DIV_LO)) u_baud (
    .clk(clk), .rst(rst), .mode(cfg_clk_mode),
    .restart(restart), .active(active), .tick(tick)
  );

  srx_framer u_framer (
    .clk(clk), .rst(rst), .serial_in(rx_serial), .rx_en(cfg_rx_en),
    .word_code(cfg_word_len), .par_en(cfg_par_en), .par_even(cfg_par_even),
    .two_stop(cfg_stop == 2'b11), .tick(tick), .restart(restart),
    .active(active), .push_q(push), .entry_q(new_entry)
  );

  srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_entry(new_entry),
    .pop(pop_ok), .head(head), .count(count), .ovr_event(ovr_event)
  );

  srx_irq u_irq (
    .clk(clk), .rst(rst), .push(push), .par_err(new_entry.par),
    .frm_err(new_entry.frm), .overrun(ovr_event), .mode(cfg_irq_mode),
    .arm(cmd_arm_first), .irq_q(irq_req), .type_q(irq_type)
  );

  assign st_char_avail = (count != '0);
  assign pop_ok        = rd_en && st_char_avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data        <= '0;
      st_parity_err  <= 1'b0;
      st_overrun_err <= 1'b0;
      st_framing_err <= 1'b0;
    end else begin
      if (cmd_err_reset) begin
        st_parity_err  <= 1'b0;
        st_overrun_err <= 1'b0;
        st_framing_err <= 1'b0;
      end
      if (pop_ok) begin
        rd_data        <= head.data;
        st_framing_err <= head.frm;
        if (head.par) st_parity_err  <= 1'b1;
        if (head.ovr) st_overrun_err <= 1'b1;
      end
    end
  end

  p_par_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (st_parity_err && !cmd_err_reset) |=> st_parity_err);

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (st_overrun_err && !cmd_err_reset) |=> st_overrun_err);

  p_err_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_err_reset && !pop_ok) |=> (!st_parity_err && !st_overrun_err && !st_framing_err));

  p_empty_read_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !st_char_avail) |=> $stable(rd_data));

endmodule

// File: tb/tb_serial_rx_channel.sv
module tb_serial_rx_channel;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_serial = 1'b1;
  logic cfg_rx_en = 1'b1;
  logic [1:0] cfg_clk_mode = 2'b00, cfg_word_len = 2'b11, cfg_stop = 2'b01, cfg_irq_mode = 2'b00;
  logic cfg_par_en = 1'b0, cfg_par_even = 1'b0;
  logic cmd_arm_first = 1'b0, cmd_err_reset = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic st_char_avail, st_parity_err, st_overrun_err, st_framing_err, irq_req;
  logic [1:0] irq_type;

  int checks = 0, errors = 0, irq_cnt = 0;
  logic [1:0] last_type = 2'b00;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_channel dut (
    .clk(clk), .rst(rst), .rx_serial(rx_serial), .cfg_rx_en(cfg_rx_en),
    .cfg_clk_mode(cfg_clk_mode), .cfg_word_len(cfg_word_len),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_stop(cfg_stop),
    .cfg_irq_mode(cfg_irq_mode), .cmd_arm_first(cmd_arm_first),
    .cmd_err_reset(cmd_err_reset), .rd_en(rd_en), .rd_data(rd_data),
    .st_char_avail(st_char_avail), .st_parity_err(st_parity_err),
    .st_overrun_err(st_overrun_err), .st_framing_err(st_framing_err),
    .irq_req(irq_req), .irq_type(irq_type)
  );

  always @(negedge clk) if (irq_req) begin irq_cnt++; last_type = irq_type; end

  typedef struct packed {
    logic [1:0] cm, wl;
    logic pe, pev, two, bpar, bstop;
    logic [1:0] im;
    logic [7:0] d, ed;
    logic epar, efrm;
    logic [1:0] eirq;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 8'hA5, 8'hA5, 1'b0, 1'b0, 2'b10},
    '{2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 8'hF3, 8'h13, 1'b0, 1'b0, 2'b10},
    '{2'd0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 8'h55, 8'h55, 1'b0, 1'b0, 2'b10},
    '{2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 8'h2A, 8'h2A, 1'b1, 1'b0, 2'b11},
    '{2'd0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 8'h3C, 8'h3C, 1'b0, 1'b1, 2'b11},
    '{2'd3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 8'h81, 8'h81, 1'b1, 1'b0, 2'b10},
    '{2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h7E, 8'h7E, 1'b0, 1'b0, 2'b00}
  };

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int div_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 16 : (c == 2'd2) ? 32 : 64;
  endfunction

  function automatic int bits_of(input logic [1:0] c);
    return (c == 2'd0) ? 5 : (c == 2'd1) ? 7 : (c == 2'd2) ? 6 : 8;
  endfunction

  task automatic send_char(input logic [7:0] d, input bit bad_par, input bit bad_stop1, input bit bad_last);
    int dv = div_of(cfg_clk_mode);
    int nb = bits_of(cfg_word_len);
    logic p = 1'b0;
    rx_serial = 1'b0; hold(dv);
    for (int i = 0; i < nb; i++) begin
      rx_serial = d[i]; p ^= d[i]; hold(dv);
    end
    if (cfg_par_en) begin
      rx_serial = (cfg_par_even ? p : ~p) ^ bad_par; hold(dv);
    end
    if (cfg_stop == 2'b11) begin rx_serial = ~bad_stop1; hold(dv); end
    rx_serial = ~bad_last; hold(dv);
    rx_serial = 1'b1; hold(2*dv + 4);
  endtask

  task automatic read_char();
    rd_en = 1'b1; hold(1); rd_en = 1'b0; hold(1);
  endtask

  task automatic err_reset();
    cmd_err_reset = 1'b1; hold(1); cmd_err_reset = 1'b0; hold(1);
  endtask

  task automatic set_cfg(input logic [1:0] cm, input logic [1:0] wl, input logic pe,
                         input logic pev, input logic two, input logic [1:0] im);
    cfg_clk_mode = cm; cfg_word_len = wl; cfg_par_en = pe; cfg_par_even = pev;
    cfg_stop = two ? 2'b11 : 2'b01; cfg_irq_mode = im;
    hold(2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    hold(3); rst = 1'b0; hold(2);

    // R12 reset state
    check(st_char_avail == 0, "R12", "char_avail after reset", st_char_avail, 0);
    check({st_parity_err, st_overrun_err, st_framing_err} == 0, "R12", "flags after reset",
          {st_parity_err, st_overrun_err, st_framing_err}, 0);
    check(rd_data == 0 && irq_cnt == 0, "R12", "data/irq after reset", rd_data, 0);

    // Table walk: R1 R2 R4 R5 R10
    foreach (VECS[k]) begin
      set_cfg(VECS[k].cm, VECS[k].wl, VECS[k].pe, VECS[k].pev, VECS[k].two, VECS[k].im);
      base = irq_cnt;
      send_char(VECS[k].d, VECS[k].bpar, 1'b0, VECS[k].bstop);
      check(st_char_avail == 1, "R1", $sformatf("vec%0d char_avail", k), st_char_avail, 1);
      read_char();
      check(rd_data == VECS[k].ed, "R2", $sformatf("vec%0d data", k), rd_data, VECS[k].ed);
      check(st_parity_err == VECS[k].epar, "R4", $sformatf("vec%0d parity", k), st_parity_err, VECS[k].epar);
      check(st_framing_err == VECS[k].efrm, "R5", $sformatf("vec%0d framing", k), st_framing_err, VECS[k].efrm);
      check((irq_cnt - base) == ((VECS[k].eirq != 0) ? 1 : 0), "R10", $sformatf("vec%0d irq count", k),
            irq_cnt - base, (VECS[k].eirq != 0) ? 1 : 0);
      if (VECS[k].eirq != 0)
        check(last_type == VECS[k].eirq, "R10", $sformatf("vec%0d irq type", k), last_type, VECS[k].eirq);
      err_reset();
    end

    // R5 first of two stop bits low
    set_cfg(2'd0, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0);
    send_char(8'h66, 1'b0, 1'b1, 1'b0);
    read_char();
    check(st_framing_err == 1, "R5", "first stop low framing", st_framing_err, 1);
    err_reset();

    // R6 R7 fill and overrun
    set_cfg(2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0);
    send_char(8'h11, 0, 0, 0); send_char(8'h22, 0, 0, 0);
    send_char(8'h33, 0, 0, 0); send_char(8'h44, 0, 0, 0);
    read_char();
    check(rd_data == 8'h11, "R6", "oldest first", rd_data, 8'h11);
    read_char();
    check(rd_data == 8'h22 && st_overrun_err == 0, "R7", "second kept, no overrun yet", rd_data, 8'h22);
    read_char();
    check(rd_data == 8'h44, "R7", "newest slot overwritten", rd_data, 8'h44);
    check(st_overrun_err == 1, "R7", "overrun tag", st_overrun_err, 1);
    check(st_char_avail == 0, "R6", "empty after three reads", st_char_avail, 0);
    read_char();
    check(rd_data == 8'h44 && st_overrun_err == 1, "R8", "empty read no effect", rd_data, 8'h44);
    err_reset();
    check({st_parity_err, st_overrun_err, st_framing_err} == 0, "R9", "error reset clears",
          {st_parity_err, st_overrun_err, st_framing_err}, 0);

    // R8 sticky parity, non-sticky framing
    set_cfg(2'd0, 2'd3, 1'b1, 1'b1, 1'b0, 2'd0);
    send_char(8'h0F, 1'b1, 0, 0); send_char(8'hF0, 0, 0, 0);
    read_char(); read_char();
    check(st_parity_err == 1, "R8", "parity sticky over clean read", st_parity_err, 1);
    err_reset();
    cfg_par_en = 1'b0; hold(2);
    send_char(8'h5A, 0, 0, 1'b1); send_char(8'hA5, 0, 0, 0);
    read_char();
    check(st_framing_err == 1, "R8", "framing from first entry", st_framing_err, 1);
    read_char();
    check(st_framing_err == 0, "R8", "framing follows clean entry", st_framing_err, 0);
    err_reset();

    // R3 receiver disabled
    set_cfg(2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 2'd3);
    cfg_rx_en = 1'b0; hold(1);
    base = irq_cnt;
    send_char(8'h00, 0, 0, 0);
    check(st_char_avail == 0, "R3", "disabled receiver stores nothing", st_char_avail, 0);
    check(irq_cnt == base, "R3", "disabled receiver no irq", irq_cnt - base, 0);
    cfg_rx_en = 1'b1; hold(1);

    // R11 first-character mode
    set_cfg(2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 2'd1);
    cmd_arm_first = 1'b1; hold(1); cmd_arm_first = 1'b0; hold(1);
    base = irq_cnt;
    send_char(8'h31, 0, 0, 0);
    check(irq_cnt - base == 1 && last_type == 2'b10, "R11", "armed first char receive irq", irq_cnt - base, 1);
    send_char(8'h32, 0, 0, 0);
    check(irq_cnt - base == 1, "R11", "second clean char silent", irq_cnt - base, 1);
    send_char(8'h33, 1'b1, 0, 0);
    check(irq_cnt - base == 2 && last_type == 2'b11, "R11", "error when disarmed special", last_type, 2'b11);

    // R12 reset mid-use
    check(st_char_avail == 1, "R12", "FIFO holds data before reset", st_char_avail, 1);
    read_char();
    rst = 1'b1; hold(2); rst = 1'b0; hold(1);
    check(st_char_avail == 0 && rd_data == 0, "R12", "reset empties FIFO", st_char_avail, 0);
    check(st_parity_err == 0, "R12", "reset clears flags", st_parity_err, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule